// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block turns three asynchronous interrupt pins into one-cycle request pulses for a downstream interrupt flag bank. Each pin first passes through a two-flop synchronizer. Pin A then goes through a noise filter that samples on a selectable clock-enable tick. The filter's output changes only when two consecutive samples agree on a new level. Pin B goes straight to its edge detector. Pin C always reports both edges.

Pin A has a 4-bit mode register. Bits [1:0] choose the edge to detect, and bit 3 chooses the sampling rate. Pin B has a 2-bit edge-select register. Reset sets both registers to zero, which means rising-edge detection with the fast sampling tick. If the selected tick stops, pin A can no longer change its filtered level, so it raises no requests.

Top module: `ext_irq_edge_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, every request output is 0. After reset, both mode registers hold zero: pins A and B detect rising edges only, and pin A uses the fast tick.
- R2: An unfiltered pin (B or C) that changes level just after a clock edge produces its request in the cycle after the third following rising clock edge: two synchronizer stages plus one detector register.
- R3: The edge code in mode A bits [1:0] and in mode B bits [1:0] means: 00 rising, 01 falling, 10 both edges, 11 no detection.
- R4: Pin C requests on every rising and every falling edge, with no configuration.
- R5: Pin A's filtered level takes a new value only when two consecutive selected ticks both sample that value. A pulse seen by at most one tick yields no request. A pulse that spans two or more tick periods yields requests as its edge code dictates.
- R6: Mode A bit 3 selects the filter tick: 0 selects `tick_fast` and 1 selects `tick_slow`.
- R7: While the selected tick is held low, pin A's filtered level holds its value and pin A produces no request.
- R8: Writing a mode register while its pin is steady produces no request. The stored previous level is not disturbed by the write.
- R9: Each detected edge produces exactly one single-cycle pulse, so the number of pulses equals the number of qualifying edges.
- R10: Bit 2 of mode A has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Raw pin with noise filter |
| pin_b | input | 1 | Raw pin with selectable edge |
| pin_c | input | 1 | Raw pin, both edges |
| tick_fast | input | 1 | Fast sampling clock enable |
| tick_slow | input | 1 | Slow sampling clock enable |
| mode_a_we | input | 1 | Write strobe for mode A |
| mode_a_wdata | input | 4 | Mode A value: [1:0] edge code, [3] rate select |
| mode_b_we | input | 1 | Write strobe for mode B |
| mode_b_wdata | input | 2 | Mode B edge code |
| req_a | output | 1 | Request pulse, pin A |
| req_b | output | 1 | Request pulse, pin B |
| req_c | output | 1 | Request pulse, pin C |

## Verification
The assertions assume that reset is held for at least one clock edge, so that the synchronizer, filter and detector registers all start from the same low level. They also assume the tick inputs are one-cycle clock enables that are sampled synchronously. The stimulus drives every pin, tick and write strobe on the falling clock edge. Its ticks come from a free-running cycle counter with fixed periods of 4 and 16 cycles. Pulse widths are chosen to lie clearly below one tick period or at or above two, so that the expected outcome never depends on tick phase.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int EDGE_W   = 2;
    localparam int MODE_A_W = 4;
    localparam int RATE_BIT = 3;

    typedef enum logic [EDGE_W-1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic       slow;
        edge_mode_e edge_sel;
    } filt_mode_t;

    function automatic logic edge_hit(edge_mode_e m, logic prev, logic cur);
        case (m)
            EDGE_RISE: return !prev && cur;
            EDGE_FALL: return prev && !cur;
            EDGE_BOTH: return prev != cur;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic filt_mode_t decode_mode_a(logic [MODE_A_W-1:0] w);
        filt_mode_t m;
        m.slow     = w[RATE_BIT];
        m.edge_sel = edge_mode_e'(w[EDGE_W-1:0]);
        return m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/noise_filter.sv
module noise_filter (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic level
);
    logic smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp   <= 1'b0;
            level <= 1'b0;
        end else if (tick) begin
            smp <= din;
            if (din == smp) level <= din;
        end
    end
endmodule

// File: rtl/edge_detect.sv
module edge_detect
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_mode_e mode,
    input  logic       lvl,
    output logic       req
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            req  <= 1'b0;
        end else begin
            prev <= lvl;
            req  <= edge_hit(mode, prev, lvl);
        end
    end
endmodule

// File: rtl/ext_irq_edge_top.sv
module ext_irq_edge_top
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_a,
    input  logic                pin_b,
    input  logic                pin_c,
    input  logic                tick_fast,
    input  logic                tick_slow,
    input  logic                mode_a_we,
    input  logic [MODE_A_W-1:0] mode_a_wdata,
    input  logic                mode_b_we,
    input  logic [EDGE_W-1:0]   mode_b_wdata,
    output logic                req_a,
    output logic                req_b,
    output logic                req_c
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] sync;
    logic             sync_a, sync_b, sync_c;
    logic             filt_a;
    logic             tick_sel;
    filt_mode_t       mode_a_q;
    edge_mode_e       mode_b_q;

    assign raw = {pin_c, pin_b, pin_a};

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[i]),
            .q   (sync[i])
        );
    end

    assign sync_a = sync[0];
    assign sync_b = sync[1];
    assign sync_c = sync[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_a_q <= '{slow: 1'b0, edge_sel: EDGE_RISE};
            mode_b_q <= EDGE_RISE;
        end else begin
            if (mode_a_we) mode_a_q <= decode_mode_a(mode_a_wdata);
            if (mode_b_we) mode_b_q <= edge_mode_e'(mode_b_wdata);
        end
    end

    assign tick_sel = mode_a_q.slow ? tick_slow : tick_fast;

    noise_filter u_filt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_sel),
        .din   (sync_a),
        .level (filt_a)
    );

    edge_detect u_det_a (
        .clk (clk), .rst (rst), .mode (mode_a_q.edge_sel), .lvl (filt_a), .req (req_a)
    );
    edge_detect u_det_b (
        .clk (clk), .rst (rst), .mode (mode_b_q), .lvl (sync_b), .req (req_b)
    );
    edge_detect u_det_c (
        .clk (clk), .rst (rst), .mode (EDGE_BOTH), .lvl (sync_c), .req (req_c)
    );
endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_sel,
    input logic       sync_a,
    input logic       sync_b,
    input logic       sync_c,
    input logic       filt_a,
    input logic [1:0] edge_a,
    input logic [1:0] edge_b,
    input logic       req_a,
    input logic       req_b,
    input logic       req_c
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!req_a && !req_b && !req_c));

    // R7
    filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_sel |=> (filt_a == $past(filt_a)));

    // R5
    filter_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_a != $past(filt_a)) |-> ($past(tick_sel) && $past(sync_a) == filt_a));

    // R3
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_a == 2'b11) |=> !req_a);

    // R3
    rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req_b && $past(edge_b) == 2'b00) |-> $past(sync_b));

    // R4
    both_edge_chk: assert property (@(posedge clk) disable iff (rst)
        req_c |-> ($past(sync_c) != $past(sync_c, 2)));

    // R9
    filt_edge_chk: assert property (@(posedge clk) disable iff (rst)
        req_a |-> ($past(filt_a) != $past(filt_a, 2)));
endmodule

bind ext_irq_edge_top ext_irq_edge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_sel (tick_sel),
    .sync_a   (sync_a),
    .sync_b   (sync_b),
    .sync_c   (sync_c),
    .filt_a   (filt_a),
    .edge_a   (mode_a_q.edge_sel),
    .edge_b   (mode_b_q),
    .req_a    (req_a),
    .req_b    (req_b),
    .req_c    (req_c)
);

// File: tb/ext_irq_edge_top_tb.sv
module ext_irq_edge_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FAST_P     = 4;
    localparam int SLOW_P     = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0;
    logic       tick_fast = 1'b0, tick_slow = 1'b0;
    logic       mode_a_we = 1'b0, mode_b_we = 1'b0;
    logic [3:0] mode_a_wdata = '0;
    logic [1:0] mode_b_wdata = '0;
    logic       req_a, req_b, req_c;

    int total = 0;
    int bad = 0;
    int cnt_a = 0, cnt_b = 0, cnt_c = 0;
    int cyc = 0;
    bit tick_run = 1'b1;

    ext_irq_edge_top u_dut (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .tick_fast(tick_fast), .tick_slow(tick_slow),
        .mode_a_we(mode_a_we), .mode_a_wdata(mode_a_wdata),
        .mode_b_we(mode_b_we), .mode_b_wdata(mode_b_wdata),
        .req_a(req_a), .req_b(req_b), .req_c(req_c)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        cyc++;
        tick_fast = tick_run && (cyc % FAST_P == 0);
        tick_slow = tick_run && (cyc % SLOW_P == 0);
    end

    initial forever begin
        @(negedge clk);
        if (req_a) cnt_a++;
        if (req_b) cnt_b++;
        if (req_c) cnt_c++;
    end

    task automatic check(int actual, int expected, string tag);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        @(negedge clk);
        cnt_a = 0; cnt_b = 0; cnt_c = 0;
    endtask

    task automatic wr_modes(logic [3:0] a, logic [1:0] b);
        @(negedge clk);
        mode_a_we = 1'b1; mode_a_wdata = a;
        mode_b_we = 1'b1; mode_b_wdata = b;
        @(negedge clk);
        mode_a_we = 1'b0; mode_b_we = 1'b0;
    endtask

    task automatic pulse_a(int w);
        @(negedge clk);
        pin_a = 1'b1;
        idle(w);
        pin_a = 1'b0;
    endtask

    function automatic int rise_hits(int code);
        return (code == 0 || code == 2) ? 1 : 0;
    endfunction

    function automatic int fall_hits(int code);
        return (code == 1 || code == 2) ? 1 : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5);
        // R1: outputs quiet during reset
        check(req_a + req_b + req_c, 0, "R1 reset outputs");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_a + req_b + req_c, 0, "R1 first cycle after reset");
        clr();

        // R1: default is rising edge on A and B
        pin_a = 1'b1; pin_b = 1'b1; pin_c = 1'b1;
        idle(30);
        check(cnt_a, 1, "R1 default rise A");
        check(cnt_b, 1, "R1 default rise B");
        pin_a = 1'b0; pin_b = 1'b0; pin_c = 1'b0;
        idle(30);
        check(cnt_a, 1, "R1 default no fall A");
        check(cnt_b, 1, "R1 default no fall B");
        check(cnt_c, 2, "R4 pin C both edges default");

        // R2: exact latency on B
        pin_b = 1'b1;
        @(negedge clk); check(req_b, 0, "R2 latency cycle 1");
        @(negedge clk); check(req_b, 0, "R2 latency cycle 2");
        @(negedge clk); check(req_b, 1, "R2 latency cycle 3");
        @(negedge clk); check(req_b, 0, "R9 single cycle pulse");
        pin_b = 1'b0;
        idle(20);

        // R3 / R4: sweep all edge codes
        for (int code = 0; code < 4; code++) begin
            wr_modes(4'(code), 2'(code));
            clr();
            pin_a = 1'b1; pin_b = 1'b1; pin_c = 1'b1;
            idle(30);
            check(cnt_a, rise_hits(code), $sformatf("R3 A rise code %0d", code));
            check(cnt_b, rise_hits(code), $sformatf("R3 B rise code %0d", code));
            check(cnt_c, 1, "R4 C rise");
            pin_a = 1'b0; pin_b = 1'b0; pin_c = 1'b0;
            idle(30);
            check(cnt_a, rise_hits(code) + fall_hits(code), $sformatf("R3 A fall code %0d", code));
            check(cnt_b, rise_hits(code) + fall_hits(code), $sformatf("R3 B fall code %0d", code));
            check(cnt_c, 2, "R4 C fall");
        end

        // R8: mode writes with steady pins raise nothing
        for (int lv = 0; lv < 2; lv++) begin
            pin_a = 1'(lv); pin_b = 1'(lv);
            idle(30);
            clr();
            for (int code = 0; code < 4; code++) begin
                wr_modes(4'(code), 2'(code));
                idle(5);
            end
            check(cnt_a, 0, $sformatf("R8 A write at level %0d", lv));
            check(cnt_b, 0, $sformatf("R8 B write at level %0d", lv));
        end
        pin_a = 1'b0; pin_b = 1'b0;
        idle(30);

        // R5: fast tick, both edges; narrow pulses dropped, wide ones kept
        wr_modes(4'b0010, 2'b10);
        for (int w = 1; w <= 12; w++) begin
            if (w > FAST_P && w < 2*FAST_P) continue;
            clr();
            pulse_a(w);
            idle(40);
            check(cnt_a, (w >= 2*FAST_P) ? 2 : 0, $sformatf("R5 fast width %0d", w));
        end

        // R6: slow tick selected by bit 3
        wr_modes(4'b1010, 2'b10);
        clr();
        pulse_a(12);
        idle(80);
        check(cnt_a, 0, "R6 slow rejects width 12");
        clr();
        pulse_a(2*SLOW_P + 8);
        idle(80);
        check(cnt_a, 2, "R6 slow accepts width 40");

        // R7: stopped tick blocks pin A
        wr_modes(4'b0010, 2'b10);
        tick_run = 1'b0;
        clr();
        pulse_a(40);
        idle(40);
        check(cnt_a, 0, "R7 no tick no request");
        tick_run = 1'b1;
        idle(40);
        check(cnt_a, 0, "R7 filter held low level");

        // R10: bit 2 ignored
        wr_modes(4'b0100, 2'b10);
        clr();
        pulse_a(12);
        idle(40);
        check(cnt_a, 1, "R10 bit2 with rise code");
        wr_modes(4'b0111, 2'b10);
        clr();
        pulse_a(12);
        idle(40);
        check(cnt_a, 0, "R10 bit2 with off code");

        // R9: fast toggles on B give one pulse per edge
        clr();
        for (int k = 0; k < 10; k++) begin
            pin_b = ~pin_b;
            idle(3);
        end
        idle(10);
        check(cnt_b, 10, "R9 pulse count B");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule